// File: doc/BRIEF.md
# Write-Only Key Register Bank

This block holds the secret keys that feed a symmetric cipher engine and a keyed-hash engine. Each processing channel owns one cipher key slot (128-bit or 256-bit) and one MAC key slot (512-bit). Keys are loaded 32 bits at a time over a simple register bus. No bus read can ever return them. A per-channel configuration write starts a fresh load. It fixes the key length and records whether the key serves approved or non-approved algorithm use.

When an engine wants to start an operation on a channel, it raises a request that names the slot type and the approval class of the algorithm. The bank starts the operation only if the slot holds a complete key of the matching class. Otherwise it raises a one-cycle key error. The bank also sits in front of the per-channel input FIFOs. It forwards a push only when the requesting channel owns the target FIFO. Any other push is dropped and a sticky violation flag is set. That flag is readable and is cleared by writing a one.

Top module: `keybank_top`

## Requirements
- R1: A bus read of any address returns zero on `bus_rdata` in the cycle after `bus_rd`. The single exception is the status address (all address bits one), which returns the violation flag in bit 0 and zero elsewhere.
- R2: While `rst` is high at a clock edge, every slot is cleared: its words are zero, its valid flag is low and it has no class. The violation flag is also cleared. After reset, every operation request gets `key_error`.
- R3: Config bit 1 selects the cipher key length. With the bit set, the key is 256 bits: eight words at offsets 0..7, and offset 7 is the final word. With the bit clear, the key is 128 bits at offsets 0..3, with offset 3 final. In that case, writes to offsets 4..7 are discarded and the upper key half stays zero.
- R4: The MAC key is 512 bits, written as sixteen words at offsets 16..31. Offset 31 is the final word.
- R5: A slot becomes valid when its final word is written. It becomes invalid when any other in-length word of it is written. A write to the channel config register (offset 32) invalidates both slots of that channel.
- R6: Each slot keeps the class given at config time. Config bit 0 sets the cipher class and bit 2 sets the MAC class, with 1 meaning approved. A request whose `op_approved` differs from the slot class gives a `key_error` pulse, with no `op_start` and a zero `op_key`, in the next cycle.
- R7: A request on a slot that is not valid gives a `key_error` pulse and no `op_start` in the next cycle.
- R8: A request that passes both checks gives an `op_start` pulse in the next cycle. In that same cycle `op_key` carries the key, with word i at bits [32i+31:32i]; a cipher key is zero-extended to 512 bits. In every other cycle `op_key` is zero.
- R9: A push whose source channel equals its destination produces, in the next cycle, a one-hot `fifo_push` on the destination and the pushed word on `fifo_data`.
- R10: A push whose source differs from its destination produces no `fifo_push` and sets `access_violation` at the next edge.
- R11: `access_violation` holds until a bus write to the status address with data bit 0 set. A write with bit 0 clear has no effect, and a violation in the same cycle as the clear wins.
- R12: A config write zeroes every stored word of both slots of that channel.

Channel c occupies word addresses c*64 .. c*64+63. Addresses with bits above the channel field nonzero, other than the status address, decode to nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears all key material |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | WORD_W | Write data |
| bus_rdata | output | WORD_W | Registered read data |
| op_req | input | 1 | Operation start request |
| op_ch | input | CH_W | Channel of the request |
| op_mac | input | 1 | 1 selects the MAC slot, 0 the cipher slot |
| op_approved | input | 1 | Approval class of the requested algorithm |
| op_start | output | 1 | Operation accepted (pulse) |
| key_error | output | 1 | Operation refused (pulse) |
| op_key | output | MK_WORDS*WORD_W | Key for the accepted operation |
| push_req | input | 1 | FIFO push request |
| push_src | input | CH_W | Channel issuing the push |
| push_dst | input | CH_W | FIFO targeted by the push |
| push_data | input | WORD_W | Word to push |
| fifo_push | output | NUM_CH | Registered per-FIFO push strobes |
| fifo_data | output | WORD_W | Registered pushed word |
| access_violation | output | 1 | Sticky foreign-FIFO push flag |

## Verification
All results are one register stage behind their stimulus, and each has a fixed point of appearance:
- `bus_rdata` reflects the read strobe from the previous edge.
- `op_start`, `key_error` and `op_key` reflect the request from the previous edge. They judge the request against slot state as it stood before that edge, so a key completed by a bus write at edge n can be used by a request presented at edge n+1.
- `fifo_push` and `fifo_data` follow the push by one edge.
- `access_violation` changes at the edge of the blocked push or of the clearing write.

The bench drives every stimulus just after a falling edge and samples at the next falling edge, which lands exactly one rising edge later. It updates its own model of the slots only after that edge.

// File: rtl/kb_pkg.sv
package kb_pkg;
  // Word offsets inside one channel's 64-word window
  localparam int KB_LOCAL_W = 6;
  localparam int KB_OFF_MAC = 16;
  localparam int KB_OFF_CFG = 32;
  // Config register bit positions
  localparam int KB_CFG_CK_APPR = 0;
  localparam int KB_CFG_CK_LONG = 1;
  localparam int KB_CFG_MK_APPR = 2;

  typedef struct packed {
    logic valid;
    logic approved;
  } slot_state_t;
endpackage

// File: rtl/kb_decode.sv
module kb_decode
  import kb_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 12,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int TOP_W = ADDR_W - KB_LOCAL_W - CH_W
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_CH-1:0] ck_we,
  output logic [NUM_CH-1:0] mk_we,
  output logic [NUM_CH-1:0] cfg_we,
  output logic [3:0]        word_idx,
  output logic              stat_hit
);
  logic [KB_LOCAL_W-1:0] local_off;
  logic [CH_W-1:0]       chan;
  logic                  in_range;

  assign local_off = addr[KB_LOCAL_W-1:0];
  assign chan      = addr[KB_LOCAL_W +: CH_W];
  assign in_range  = (addr[ADDR_W-1 -: TOP_W] == '0);
  assign stat_hit  = (addr == {ADDR_W{1'b1}});
  assign word_idx  = local_off[3:0];

  always_comb begin
    ck_we  = '0;
    mk_we  = '0;
    cfg_we = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (wr && in_range && (chan == CH_W'(c))) begin
        ck_we[c]  = (local_off[5:3] == 3'd0);
        mk_we[c]  = (local_off[5:4] == 2'(KB_OFF_MAC / 16));
        cfg_we[c] = (local_off == KB_LOCAL_W'(KB_OFF_CFG));
      end
    end
  end
endmodule

// File: rtl/kb_slot.sv
module kb_slot #(
  parameter int WORDS      = 8,
  parameter int WORD_W     = 32,
  parameter bit FIXED_LONG = 1'b0,
  localparam int IDXW      = $clog2(WORDS),
  localparam int KEY_W     = WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDXW-1:0]   wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              cfg_en,
  input  logic              cfg_appr,
  input  logic              cfg_long,
  output logic [KEY_W-1:0]  key,
  output logic              valid,
  output logic              approved
);
  logic [WORD_W-1:0] mem [WORDS];
  logic              long_q;
  logic [IDXW-1:0]   last_idx;
  logic              in_len;

  assign last_idx = (FIXED_LONG || long_q) ? IDXW'(WORDS - 1) : IDXW'(WORDS / 2 - 1);
  assign in_len   = (wr_idx <= last_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      valid    <= 1'b0;
      approved <= 1'b0;
      long_q   <= 1'b0;
    end else if (cfg_en) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      valid    <= 1'b0;
      approved <= cfg_appr;
      long_q   <= cfg_long;
    end else if (wr_en && in_len) begin
      mem[wr_idx] <= wr_data;
      valid       <= (wr_idx == last_idx);
    end
  end

  for (genvar i = 0; i < WORDS; i++) begin : g_flat
    assign key[i*WORD_W +: WORD_W] = mem[i];
  end

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (!valid && key == '0)); // R2
  AST_CFG_INVALIDATES: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> (!valid && key == '0)); // R12
  AST_VALID_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> $past(wr_en && !cfg_en)); // R5
endmodule

// File: rtl/kb_fifo_gate.sv
module kb_fifo_gate #(
  parameter int NUM_CH = 4,
  parameter int WORD_W = 32,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_req,
  input  logic [CH_W-1:0]   push_src,
  input  logic [CH_W-1:0]   push_dst,
  input  logic [WORD_W-1:0] push_data,
  output logic [NUM_CH-1:0] fifo_push,
  output logic [WORD_W-1:0] fifo_data,
  output logic              blocked
);
  logic allowed;

  assign allowed = push_req && (push_src == push_dst);
  assign blocked = push_req && (push_src != push_dst);

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_push <= '0;
      fifo_data <= '0;
    end else begin
      fifo_push <= '0;
      fifo_data <= '0;
      if (allowed) begin
        fifo_push[push_dst] <= 1'b1;
        fifo_data           <= push_data;
      end
    end
  end

  AST_PUSH_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fifo_push)); // R9
  AST_FOREIGN_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (push_req && push_src != push_dst) |=> (fifo_push == '0)); // R10
endmodule

// File: rtl/keybank_top.sv
module keybank_top
  import kb_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int ADDR_W   = 12,
  parameter int WORD_W   = 32,
  parameter int CK_WORDS = 8,
  parameter int MK_WORDS = 16,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CK_W    = CK_WORDS * WORD_W,
  localparam int MK_W    = MK_WORDS * WORD_W,
  localparam int CK_IDXW = $clog2(CK_WORDS),
  localparam int MK_IDXW = $clog2(MK_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              op_req,
  input  logic [CH_W-1:0]   op_ch,
  input  logic              op_mac,
  input  logic              op_approved,
  output logic              op_start,
  output logic              key_error,
  output logic [MK_W-1:0]   op_key,
  input  logic              push_req,
  input  logic [CH_W-1:0]   push_src,
  input  logic [CH_W-1:0]   push_dst,
  input  logic [WORD_W-1:0] push_data,
  output logic [NUM_CH-1:0] fifo_push,
  output logic [WORD_W-1:0] fifo_data,
  output logic              access_violation
);
  logic [NUM_CH-1:0] ck_we, mk_we, cfg_we;
  logic [3:0]        word_idx;
  logic              stat_hit;
  logic              blocked;

  logic [CK_W-1:0]   ck_key [NUM_CH];
  logic [MK_W-1:0]   mk_key [NUM_CH];
  slot_state_t       ck_st  [NUM_CH];
  slot_state_t       mk_st  [NUM_CH];

  kb_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_decode (
    .wr(bus_wr), .addr(bus_addr),
    .ck_we(ck_we), .mk_we(mk_we), .cfg_we(cfg_we),
    .word_idx(word_idx), .stat_hit(stat_hit)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    kb_slot #(.WORDS(CK_WORDS), .WORD_W(WORD_W), .FIXED_LONG(1'b0)) u_ck (
      .clk(clk), .rst(rst),
      .wr_en(ck_we[c]), .wr_idx(word_idx[CK_IDXW-1:0]), .wr_data(bus_wdata),
      .cfg_en(cfg_we[c]), .cfg_appr(bus_wdata[KB_CFG_CK_APPR]),
      .cfg_long(bus_wdata[KB_CFG_CK_LONG]),
      .key(ck_key[c]), .valid(ck_st[c].valid), .approved(ck_st[c].approved)
    );
    kb_slot #(.WORDS(MK_WORDS), .WORD_W(WORD_W), .FIXED_LONG(1'b1)) u_mk (
      .clk(clk), .rst(rst),
      .wr_en(mk_we[c]), .wr_idx(word_idx[MK_IDXW-1:0]), .wr_data(bus_wdata),
      .cfg_en(cfg_we[c]), .cfg_appr(bus_wdata[KB_CFG_MK_APPR]),
      .cfg_long(1'b1),
      .key(mk_key[c]), .valid(mk_st[c].valid), .approved(mk_st[c].approved)
    );
  end

  kb_fifo_gate #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_gate (
    .clk(clk), .rst(rst),
    .push_req(push_req), .push_src(push_src), .push_dst(push_dst),
    .push_data(push_data), .fifo_push(fifo_push), .fifo_data(fifo_data),
    .blocked(blocked)
  );

  // Operation admission
  slot_state_t     sel_st;
  logic [MK_W-1:0] sel_key;
  logic            op_ok;

  always_comb begin
    if (op_mac) begin
      sel_st  = mk_st[op_ch];
      sel_key = mk_key[op_ch];
    end else begin
      sel_st  = ck_st[op_ch];
      sel_key = {{(MK_W-CK_W){1'b0}}, ck_key[op_ch]};
    end
    op_ok = op_req && sel_st.valid && (sel_st.approved == op_approved);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_start  <= 1'b0;
      key_error <= 1'b0;
      op_key    <= '0;
    end else begin
      op_start  <= op_ok;
      key_error <= op_req && !op_ok;
      op_key    <= op_ok ? sel_key : '0;
    end
  end

  // Status: sticky violation, write-one-to-clear; reads mask everything else
  logic stat_clr;
  assign stat_clr = bus_wr && stat_hit && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      access_violation <= 1'b0;
      bus_rdata        <= '0;
    end else begin
      if (blocked)       access_violation <= 1'b1;
      else if (stat_clr) access_violation <= 1'b0;
      bus_rdata <= (bus_rd && stat_hit) ? {{(WORD_W-1){1'b0}}, access_violation} : '0;
    end
  end

  AST_READ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr != {ADDR_W{1'b1}}) |=> (bus_rdata == '0)); // R1
  AST_CLASS_MISMATCH: assert property (@(posedge clk) disable iff (rst)
    (op_req && sel_st.valid && sel_st.approved != op_approved)
      |=> (key_error && !op_start && op_key == '0)); // R6
  AST_INVALID_REFUSED: assert property (@(posedge clk) disable iff (rst)
    (op_req && !sel_st.valid) |=> (key_error && !op_start)); // R7
  AST_IDLE_KEY_ZERO: assert property (@(posedge clk) disable iff (rst)
    !op_req |=> (op_key == '0 && !op_start)); // R8
  AST_VIOL_SET: assert property (@(posedge clk) disable iff (rst)
    blocked |=> access_violation); // R10
  AST_VIOL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (access_violation && !stat_clr) |=> access_violation); // R11
endmodule

// File: tb/keybank_top_test.sv
module keybank_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam logic [11:0] STAT = 12'hFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 0, bus_rd = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        op_req = 0, op_mac = 0, op_approved = 0;
  logic [1:0]  op_ch = '0;
  logic        op_start, key_error;
  logic [511:0] op_key;
  logic        push_req = 0;
  logic [1:0]  push_src = '0, push_dst = '0;
  logic [31:0] push_data = '0;
  logic [3:0]  fifo_push;
  logic [31:0] fifo_data;
  logic        access_violation;

  always #(CLK_PERIOD/2) clk = ~clk;

  keybank_top uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .op_req(op_req), .op_ch(op_ch),
    .op_mac(op_mac), .op_approved(op_approved), .op_start(op_start),
    .key_error(key_error), .op_key(op_key), .push_req(push_req),
    .push_src(push_src), .push_dst(push_dst), .push_data(push_data),
    .fifo_push(fifo_push), .fifo_data(fifo_data),
    .access_violation(access_violation)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model of the requirements
  logic [31:0] mck [NCH][8];
  logic [31:0] mmk [NCH][16];
  bit mcv[NCH], mca[NCH], mcl[NCH], mmv[NCH], mma[NCH];
  bit mviol;

  task automatic check(input bit ok, input string req,
                       input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin
      for (int w = 0; w < 8; w++) mck[c][w] = '0;
      for (int w = 0; w < 16; w++) mmk[c][w] = '0;
      mcv[c] = 0; mca[c] = 0; mcl[c] = 0; mmv[c] = 0; mma[c] = 0;
    end
    mviol = 0;
  endtask

  function automatic logic [11:0] kaddr(input int ch, input int off);
    return 12'((ch << 6) | off);
  endfunction

  function automatic logic [511:0] exp_key(input int ch, input bit mac);
    logic [511:0] k = '0;
    for (int w = 0; w < 16; w++)
      k[w*32 +: 32] = mac ? mmk[ch][w] : ((w < 8) ? mck[ch][w] : 32'h0);
    return k;
  endfunction

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
    if (a == STAT) begin
      if (d[0]) mviol = 0;
    end else if (a[11:8] == 4'd0) begin
      int ch, lo, last;
      ch = int'(a[7:6]); lo = int'(a[5:0]);
      if (lo < 8) begin
        last = mcl[ch] ? 7 : 3;
        if (lo <= last) begin mck[ch][lo] = d; mcv[ch] = (lo == last); end
      end else if (lo >= 16 && lo < 32) begin
        mmk[ch][lo-16] = d; mmv[ch] = (lo == 31);
      end else if (lo == 32) begin
        for (int w = 0; w < 8; w++) mck[ch][w] = '0;
        for (int w = 0; w < 16; w++) mmk[ch][w] = '0;
        mcv[ch] = 0; mmv[ch] = 0;
        mca[ch] = d[0]; mcl[ch] = d[1]; mma[ch] = d[2];
      end
    end
  endtask

  task automatic read_chk(input logic [11:0] a, input string req);
    logic [31:0] e;
    e = (a == STAT) ? {31'b0, mviol} : 32'h0;
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    check(bus_rdata == e, req, bus_rdata, e);
  endtask

  task automatic op_chk(input int ch, input bit mac, input bit appr, input string req);
    bit ok;
    logic [511:0] ek;
    ok = mac ? (mmv[ch] && mma[ch] == appr) : (mcv[ch] && mca[ch] == appr);
    ek = ok ? exp_key(ch, mac) : '0;
    op_req = 1; op_ch = 2'(ch); op_mac = mac; op_approved = appr;
    @(negedge clk);
    op_req = 0;
    check(op_start == ok, req, op_start, ok);
    check(key_error == !ok, req, key_error, !ok);
    check(op_key == ek, req, op_key, ek);
  endtask

  task automatic push_chk(input int s, input int d, input logic [31:0] v, input string req);
    logic [3:0] ep;
    ep = (s == d) ? 4'(1 << d) : 4'h0;
    push_req = 1; push_src = 2'(s); push_dst = 2'(d); push_data = v;
    @(negedge clk);
    push_req = 0;
    if (s != d) mviol = 1;
    check(fifo_push == ep, req, fifo_push, ep);
    if (s == d) check(fifo_data == v, req, fifo_data, v);
    check(access_violation == mviol, req, access_violation, mviol);
  endtask

  task automatic load_cipher(input int ch, input int nwords);
    for (int w = 0; w < nwords; w++) bus_write(kaddr(ch, w), $urandom);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;

    // R2: reset state
    check(op_start == 0 && key_error == 0, "R2 reset outputs", {op_start, key_error}, 0);
    check(fifo_push == 0 && access_violation == 0, "R2 reset status", {fifo_push, access_violation}, 0);
    for (int c = 0; c < NCH; c++) begin
      op_chk(c, 0, 0, "R2 cipher empty after reset");
      op_chk(c, 1, 1, "R2 mac empty after reset");
    end

    // R3/R5/R7/R8: 256-bit approved key on channel 1
    bus_write(kaddr(1, 32), 32'h3);
    load_cipher(1, 7);
    op_chk(1, 0, 1, "R7 partial key refused");
    load_cipher(1, 1);
    bus_write(kaddr(1, 7), 32'hA5A5_0007);
    op_chk(1, 0, 1, "R8 long approved key start");
    op_chk(1, 0, 0, "R6 approved key non-approved op");
    // R5: rewrite of non-final word invalidates
    bus_write(kaddr(1, 1), 32'h1111_0001);
    op_chk(1, 0, 1, "R5 rewrite invalidates");
    bus_write(kaddr(1, 7), 32'hBEEF_0007);
    op_chk(1, 0, 1, "R5 final word revalidates");

    // R3: 128-bit non-approved key on channel 2; offsets 4..7 discarded
    bus_write(kaddr(2, 32), 32'h0);
    load_cipher(2, 4);
    bus_write(kaddr(2, 5), 32'hDEAD_DEAD);
    op_chk(2, 0, 0, "R3 short key upper half zero");
    op_chk(2, 0, 1, "R6 non-approved key approved op");

    // R4: MAC key on channel 3
    bus_write(kaddr(3, 32), 32'h4);
    for (int w = 0; w < 15; w++) bus_write(kaddr(3, 16 + w), $urandom);
    op_chk(3, 1, 1, "R4 mac incomplete refused");
    bus_write(kaddr(3, 31), 32'hC0DE_0015);
    op_chk(3, 1, 1, "R4 mac full key start");

    // R12: config write clears both slots
    bus_write(kaddr(1, 32), 32'h7);
    op_chk(1, 0, 1, "R12 cfg invalidates cipher");
    bus_write(kaddr(1, 7), 32'h7777_7777);
    op_chk(1, 0, 1, "R12 only final word after cfg");

    // R1: key addresses read as zero
    read_chk(kaddr(1, 7), "R1 cipher word read masked");
    read_chk(kaddr(3, 31), "R1 mac word read masked");
    read_chk(kaddr(2, 32), "R1 cfg read masked");

    // R9/R10/R11: FIFO gate and status
    push_chk(2, 2, 32'h1234_5678, "R9 own fifo push");
    push_chk(0, 3, 32'hFFFF_0000, "R10 foreign push blocked");
    read_chk(STAT, "R11 status shows violation");
    bus_write(STAT, 32'h0);
    check(access_violation == 1, "R11 write zero no effect", access_violation, 1);
    bus_write(STAT, 32'h1);
    check(access_violation == 0, "R11 write one clears", access_violation, 0);
    push_req = 1; push_src = 2'd1; push_dst = 2'd2;
    bus_wr = 1; bus_addr = STAT; bus_wdata = 32'h1;
    @(negedge clk);
    push_req = 0; bus_wr = 0; mviol = 1;
    check(access_violation == 1, "R11 set wins over clear", access_violation, 1);

    // Constrained random mix
    for (int i = 0; i < 600; i++) begin
      int ch, kind;
      ch = $urandom_range(0, NCH - 1);
      kind = $urandom_range(0, 9);
      case (kind)
        0: bus_write(kaddr(ch, 32), 32'($urandom_range(0, 7)));
        1, 2: bus_write(kaddr(ch, $urandom_range(0, 7)), $urandom);
        3, 4: bus_write(kaddr(ch, 16 + $urandom_range(0, 15)), $urandom);
        5, 6: begin
          bit mac;
          mac = 1'($urandom_range(0, 1));
          op_chk(ch, mac, $urandom_range(0, 3) == 0 ? !(mac ? mma[ch] : mca[ch])
                                                    : (mac ? mma[ch] : mca[ch]),
                 "R6 R7 R8 random op");
        end
        7: push_chk($urandom_range(0, NCH - 1), $urandom_range(0, NCH - 1),
                    $urandom, "R9 R10 random push");
        8: read_chk($urandom_range(0, 3) == 0 ? STAT : 12'($urandom), "R1 random read");
        default: bus_write(STAT, 32'($urandom_range(0, 1)));
      endcase
    end

    // R2: reset mid-run clears keys and the violation flag
    rst = 1;
    @(negedge clk);
    rst = 0;
    model_reset();
    check(access_violation == 0, "R2 reset clears violation", access_violation, 0);
    op_chk(3, 1, 1, "R2 mac cleared by reset");
    op_chk(1, 0, 1, "R2 cipher cleared by reset");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule